// File: doc/BRIEF.md
# Segmented Register Bus Multiplexer

This block decodes word-addressed register accesses from a host bus arbiter and sends each one to a group of cores. The first decode level uses the top address field to pick a segment. The segments are hash engines, random generators and ciphers. The second decode level uses the next field to pick a core slot inside that segment. The lowest field is passed to the chosen core as its register index.

Slot 0 of the hash segment is not a hash engine. It holds a small bank of board-wide registers: two read-only identification words and one scratch word that can be written. The random-generator and cipher segments are placeholders. Each holds a few read/write dummy registers in its slot 0. Hash slots from 1 upward connect to external register-file ports. Each of those slots can be left out at elaboration time.

Space with no target stays silent. Reads from it return zero and writes to it are dropped. There is no error output. Cores return read data combinationally, so the block registers the selected word, and read data always appears one clock after the access.

Top module: `regmux_top`

## Requirements
- R1: The 17-bit word address is split as follows: bits [16:15] select the segment (0 hash, 1 random generator, 2 cipher, 3 unmapped), bits [14:8] select the core slot, and bits [7:0] select the register.
- R2: `sys_rd_data` is registered. A read in clock n shows its data after edge n+1. A cycle with no read yields zero one clock later. A read that coincides with a write to the same register returns the value held before the write.
- R3: Hash slot 0 is the global bank. Register 0 returns `BOARD_ID` and register 1 returns `BUILD_VER`; both are read-only and ignore writes. Register 2 is a read/write scratch word that resets to zero.
- R4: Hash slot k (1..`HASH_CORES`) drives `core_cs[k-1]` high in each cycle that has a read or write to it. At most one chip select is high at a time. A read returns that port's `core_rd_data` word (bits [32(k-1)+31 : 32(k-1)]).
- R5: `core_we` bits are single-cycle pulses that occur only in a `sys_wr` cycle and only for the selected slot. `core_addr` carries address bits [7:0], and `core_wr_data` carries `sys_wr_data`.
- R6: A hash slot whose bit in `HASH_PRESENT` is 0 never gets a chip select or write enable. Reads from it return zero.
- R7: Slot 0 of the random-generator and cipher segments holds `DUMMY_REGS` read/write registers. Register i resets to `RNG_BASE`+i or `CIPHER_BASE`+i respectively.
- R8: The following read as zero and drop writes: segment 3, hash slots above `HASH_CORES`, slots other than 0 in the random-generator and cipher segments, global registers 3..255, and dummy registers at index `DUMMY_REGS` or above.
- R9: A synchronous active-high `rst` clears `sys_rd_data` and the scratch word and restores the dummy registers to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_addr | input | 17 | Word address from the arbiter |
| sys_wr | input | 1 | Write strobe, one cycle per write |
| sys_rd | input | 1 | Read strobe, one cycle per read |
| sys_wr_data | input | 32 | Write data |
| sys_rd_data | output | 32 | Registered read data |
| core_cs | output | HASH_CORES | Chip select per hash slot 1..HASH_CORES |
| core_we | output | HASH_CORES | Write enable per hash slot |
| core_addr | output | 8 | Register index shared by hash ports |
| core_wr_data | output | 32 | Write data shared by hash ports |
| core_rd_data | input | 32*HASH_CORES | Combinational read data from hash ports, slot k in word k-1 |

## Verification
The hardest case to reach is a read and a write to the same register in one cycle. The read must return the old value, while the write still lands one edge later. The bench drives both strobes together on the scratch word and reads it again afterwards. The next hardest case is a selected but absent slot. It looks like a normal hash address, so the stimulus sends reads and writes to the empty slot between accesses to the present slots on each side of it, and watches the chip-select lines during that cycle. A reset in the middle of the run, after the writable words have been changed, shows that each one returns to its own reset value.

// File: rtl/regmux_pkg.sv
package regmux_pkg;

    localparam int ADDR_W = 17;
    localparam int SEG_W  = 2;
    localparam int CORE_W = 7;
    localparam int REG_W  = 8;
    localparam int DATA_W = 32;

    typedef enum logic [SEG_W-1:0] {
        SEG_HASH   = 2'd0,
        SEG_RNG    = 2'd1,
        SEG_CIPHER = 2'd2,
        SEG_VOID   = 2'd3
    } seg_e;

    typedef struct packed {
        seg_e              seg;
        logic [CORE_W-1:0] core;
        logic [REG_W-1:0]  idx;
    } waddr_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        waddr_t            a;
        logic [DATA_W-1:0] wdata;
    } access_t;

    localparam logic [REG_W-1:0] GREG_BOARD   = 8'd0;
    localparam logic [REG_W-1:0] GREG_VER     = 8'd1;
    localparam logic [REG_W-1:0] GREG_SCRATCH = 8'd2;

    function automatic waddr_t split_addr(input logic [ADDR_W-1:0] a);
        return waddr_t'(a);
    endfunction

endpackage

// File: rtl/regmux_decode.sv
module regmux_decode
    import regmux_pkg::*;
#(
    parameter int                    HASH_CORES   = 3,
    parameter logic [HASH_CORES-1:0] HASH_PRESENT = '1
) (
    input  access_t               acc,
    output logic                  glob_sel,
    output logic                  rng_sel,
    output logic                  cph_sel,
    output logic [HASH_CORES-1:0] hcs,
    output logic [HASH_CORES-1:0] hwe
);

    logic active;
    logic slot0;

    always_comb begin
        active   = acc.rd | acc.wr;
        slot0    = (acc.a.core == '0);
        glob_sel = active && slot0 && (acc.a.seg == SEG_HASH);
        rng_sel  = active && slot0 && (acc.a.seg == SEG_RNG);
        cph_sel  = active && slot0 && (acc.a.seg == SEG_CIPHER);
    end

    for (genvar k = 0; k < HASH_CORES; k++) begin : g_slot
        if (HASH_PRESENT[k]) begin : g_on
            assign hcs[k] = active && (acc.a.seg == SEG_HASH)
                            && (acc.a.core == CORE_W'(k + 1));
        end else begin : g_off
            assign hcs[k] = 1'b0;
        end
        assign hwe[k] = hcs[k] & acc.wr;
    end

endmodule

// File: rtl/regmux_globals.sv
module regmux_globals
    import regmux_pkg::*;
#(
    parameter logic [DATA_W-1:0] BOARD_ID  = 32'h0000_B0A7,
    parameter logic [DATA_W-1:0] BUILD_VER = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [REG_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] scratch;

    always_ff @(posedge clk) begin
        if (rst)
            scratch <= '0;
        else if (sel && wr && idx == GREG_SCRATCH)
            scratch <= wdata;
    end

    always_comb begin
        unique case (idx)
            GREG_BOARD:   rdata = BOARD_ID;
            GREG_VER:     rdata = BUILD_VER;
            GREG_SCRATCH: rdata = scratch;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/regmux_stub_bank.sv
module regmux_stub_bank
    import regmux_pkg::*;
#(
    parameter int                N_REGS     = 2,
    parameter logic [DATA_W-1:0] RESET_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [REG_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [N_REGS];

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= RESET_BASE + DATA_W'(i);
            else if (sel && wr && idx == REG_W'(i))
                regs[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REGS; i++)
            if (idx == REG_W'(i))
                rdata = regs[i];
    end

endmodule

// File: rtl/regmux_top.sv
module regmux_top
    import regmux_pkg::*;
#(
    parameter int                    HASH_CORES   = 3,
    parameter logic [HASH_CORES-1:0] HASH_PRESENT = 3'b101,
    parameter int                    DUMMY_REGS   = 2,
    parameter logic [31:0]           BOARD_ID     = 32'h0000_B0A7,
    parameter logic [31:0]           BUILD_VER    = 32'h0001_0203,
    parameter logic [31:0]           RNG_BASE     = 32'h5200_0000,
    parameter logic [31:0]           CIPHER_BASE  = 32'hC100_0000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [16:0]                  sys_addr,
    input  logic                         sys_wr,
    input  logic                         sys_rd,
    input  logic [31:0]                  sys_wr_data,
    output logic [31:0]                  sys_rd_data,
    output logic [HASH_CORES-1:0]        core_cs,
    output logic [HASH_CORES-1:0]        core_we,
    output logic [7:0]                   core_addr,
    output logic [31:0]                  core_wr_data,
    input  logic [32*HASH_CORES-1:0]     core_rd_data
);

    access_t           acc;
    logic              glob_sel, rng_sel, cph_sel;
    logic [DATA_W-1:0] glob_rd, rng_rd, cph_rd, rd_pick;

    always_comb begin
        acc.rd    = sys_rd;
        acc.wr    = sys_wr;
        acc.a     = split_addr(sys_addr);
        acc.wdata = sys_wr_data;
    end

    regmux_decode #(
        .HASH_CORES  (HASH_CORES),
        .HASH_PRESENT(HASH_PRESENT)
    ) u_dec (
        .acc     (acc),
        .glob_sel(glob_sel),
        .rng_sel (rng_sel),
        .cph_sel (cph_sel),
        .hcs     (core_cs),
        .hwe     (core_we)
    );

    regmux_globals #(
        .BOARD_ID (BOARD_ID),
        .BUILD_VER(BUILD_VER)
    ) u_glob (
        .clk(clk), .rst(rst), .sel(glob_sel), .wr(acc.wr),
        .idx(acc.a.idx), .wdata(acc.wdata), .rdata(glob_rd)
    );

    regmux_stub_bank #(
        .N_REGS(DUMMY_REGS), .RESET_BASE(RNG_BASE)
    ) u_rng (
        .clk(clk), .rst(rst), .sel(rng_sel), .wr(acc.wr),
        .idx(acc.a.idx), .wdata(acc.wdata), .rdata(rng_rd)
    );

    regmux_stub_bank #(
        .N_REGS(DUMMY_REGS), .RESET_BASE(CIPHER_BASE)
    ) u_cph (
        .clk(clk), .rst(rst), .sel(cph_sel), .wr(acc.wr),
        .idx(acc.a.idx), .wdata(acc.wdata), .rdata(cph_rd)
    );

    assign core_addr    = acc.a.idx;
    assign core_wr_data = acc.wdata;

    always_comb begin
        rd_pick = '0;
        if (glob_sel) rd_pick = glob_rd;
        if (rng_sel)  rd_pick = rng_rd;
        if (cph_sel)  rd_pick = cph_rd;
        for (int k = 0; k < HASH_CORES; k++)
            if (core_cs[k]) rd_pick = core_rd_data[k*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            sys_rd_data <= '0;
        else
            sys_rd_data <= acc.rd ? rd_pick : '0;
    end

endmodule

// File: rtl/regmux_chk.sv
module regmux_chk #(
    parameter int                    HASH_CORES   = 3,
    parameter logic [HASH_CORES-1:0] HASH_PRESENT = '1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [16:0]           sys_addr,
    input logic                  sys_wr,
    input logic                  sys_rd,
    input logic [31:0]           sys_rd_data,
    input logic [HASH_CORES-1:0] core_cs,
    input logic [HASH_CORES-1:0] core_we
);

    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_cs));

    assert_cs_needs_access_R4: assert property (@(posedge clk) disable iff (rst)
        (|core_cs) |-> (sys_rd || sys_wr));

    assert_we_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (|core_we) |-> (sys_wr && ((core_we & ~core_cs) == '0)));

    assert_absent_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ((core_cs | core_we) & ~HASH_PRESENT) == '0);

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !sys_rd |=> (sys_rd_data == '0));

    assert_void_seg_R8: assert property (@(posedge clk) disable iff (rst)
        (sys_rd && sys_addr[16:15] == 2'b11) |=> (sys_rd_data == '0));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (sys_rd_data == '0));

endmodule

bind regmux_top regmux_chk #(
    .HASH_CORES  (HASH_CORES),
    .HASH_PRESENT(HASH_PRESENT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sys_addr   (sys_addr),
    .sys_wr     (sys_wr),
    .sys_rd     (sys_rd),
    .sys_rd_data(sys_rd_data),
    .core_cs    (core_cs),
    .core_we    (core_we)
);

// File: tb/sim_regmux_top.sv
`timescale 1ns/1ps
module sim_regmux_top;

    localparam int          NH      = 3;
    localparam logic [2:0]  PRESENT = 3'b101;
    localparam logic [31:0] BOARD   = 32'h0000_B0A7;
    localparam logic [31:0] VER     = 32'h0001_0203;
    localparam logic [31:0] RBASE   = 32'h5200_0000;
    localparam logic [31:0] CBASE   = 32'hC100_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [16:0]       sys_addr = '0;
    logic              sys_wr = 1'b0, sys_rd = 1'b0;
    logic [31:0]       sys_wr_data = '0;
    logic [31:0]       sys_rd_data;
    logic [NH-1:0]     core_cs, core_we;
    logic [7:0]        core_addr;
    logic [31:0]       core_wr_data;
    logic [32*NH-1:0]  core_rd_data;

    int checks = 0, fails = 0;
    string phase = "R9";

    always #4 clk = ~clk;

    regmux_top #(
        .HASH_CORES(NH), .HASH_PRESENT(PRESENT), .DUMMY_REGS(2),
        .BOARD_ID(BOARD), .BUILD_VER(VER), .RNG_BASE(RBASE), .CIPHER_BASE(CBASE)
    ) u0 (
        .clk(clk), .rst(rst), .sys_addr(sys_addr), .sys_wr(sys_wr),
        .sys_rd(sys_rd), .sys_wr_data(sys_wr_data), .sys_rd_data(sys_rd_data),
        .core_cs(core_cs), .core_we(core_we), .core_addr(core_addr),
        .core_wr_data(core_wr_data), .core_rd_data(core_rd_data)
    );

    // stand-in hash cores: one stored word each, read data mixes slot and index
    logic [31:0] stub_reg [NH];
    always @(posedge clk) begin
        for (int k = 0; k < NH; k++)
            if (rst) stub_reg[k] <= '0;
            else if (core_we[k]) stub_reg[k] <= core_wr_data;
    end
    always_comb begin
        for (int k = 0; k < NH; k++)
            core_rd_data[k*32 +: 32] = stub_reg[k] ^ {8'(k + 1), 16'h0, core_addr};
    end

    // behavioural reference model
    logic [31:0] m_scratch, exp_q;
    logic [31:0] m_rng [2], m_cph [2], m_hash [NH];

    function automatic logic [31:0] model_read(input logic [16:0] a);
        int seg = a[16:15], core = a[14:8], idx = a[7:0];
        if (seg == 0 && core == 0)
            return idx == 0 ? BOARD : idx == 1 ? VER : idx == 2 ? m_scratch : 32'h0;
        if (seg == 0 && core >= 1 && core <= NH && PRESENT[core-1])
            return m_hash[core-1] ^ {8'(core), 16'h0, 8'(idx)};
        if (seg == 1 && core == 0 && idx < 2) return m_rng[idx];
        if (seg == 2 && core == 0 && idx < 2) return m_cph[idx];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_q = '0; m_scratch = '0;
            for (int i = 0; i < 2; i++) begin
                m_rng[i] = RBASE + i; m_cph[i] = CBASE + i;
            end
            for (int k = 0; k < NH; k++) m_hash[k] = '0;
        end else begin
            automatic int seg = sys_addr[16:15], core = sys_addr[14:8], idx = sys_addr[7:0];
            automatic logic [31:0] v = sys_rd ? model_read(sys_addr) : 32'h0;
            if (sys_wr) begin
                if (seg == 0 && core == 0 && idx == 2) m_scratch = sys_wr_data;
                if (seg == 0 && core >= 1 && core <= NH && PRESENT[core-1])
                    m_hash[core-1] = sys_wr_data;
                if (seg == 1 && core == 0 && idx < 2) m_rng[idx] = sys_wr_data;
                if (seg == 2 && core == 0 && idx < 2) m_cph[idx] = sys_wr_data;
            end
            exp_q = v;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) if (!rst) chk({phase, " per-cycle"}, sys_rd_data, exp_q);

    logic [NH-1:0] s_cs, s_we;
    logic [7:0]    s_addr;
    logic [31:0]   s_wd;

    function automatic logic [16:0] A(input int seg, input int core, input int idx);
        return {2'(seg), 7'(core), 8'(idx)};
    endfunction

    task automatic acc(input bit w, input bit r, input logic [16:0] a, input logic [31:0] d);
        @(negedge clk);
        sys_wr = w; sys_rd = r; sys_addr = a; sys_wr_data = d;
        #1;
        s_cs = core_cs; s_we = core_we; s_addr = core_addr; s_wd = core_wr_data;
        @(posedge clk); #1;
        sys_wr = 1'b0; sys_rd = 1'b0;
    endtask

    task automatic rd(input string req, input logic [16:0] a, input logic [31:0] exp);
        acc(0, 1, a, '0);
        chk(req, sys_rd_data, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset rd_data", sys_rd_data, 32'h0);
        chk("R9 reset cs", 32'(core_cs), 32'h0);
        @(negedge clk); rst = 1'b0;

        phase = "R3";
        rd("R3 board id", A(0, 0, 0), BOARD);
        rd("R3 version", A(0, 0, 1), VER);
        rd("R3 scratch reset", A(0, 0, 2), 32'h0);
        acc(1, 0, A(0, 0, 0), 32'hDEAD_0000);
        acc(1, 0, A(0, 0, 1), 32'hDEAD_0001);
        rd("R3 board id after write", A(0, 0, 0), BOARD);
        rd("R3 version after write", A(0, 0, 1), VER);
        acc(1, 0, A(0, 0, 2), 32'hA5A5_1234);
        rd("R3 scratch readback", A(0, 0, 2), 32'hA5A5_1234);

        phase = "R2";
        acc(0, 0, A(0, 0, 2), '0);
        chk("R2 idle gives zero", sys_rd_data, 32'h0);
        acc(1, 1, A(0, 0, 2), 32'h0BAD_F00D);
        chk("R2 read with write returns old", sys_rd_data, 32'hA5A5_1234);
        rd("R2 write landed", A(0, 0, 2), 32'h0BAD_F00D);

        phase = "R4";
        acc(1, 0, A(0, 3, 8'h44), 32'h1111_2222);
        chk("R4 cs slot3", 32'(s_cs), 32'b100);
        chk("R5 we slot3", 32'(s_we), 32'b100);
        chk("R5 core_addr", 32'(s_addr), 32'h44);
        chk("R5 core_wr_data", s_wd, 32'h1111_2222);
        rd("R4 slot3 read", A(0, 3, 8'h10), 32'h1111_2222 ^ 32'h0300_0010);
        acc(0, 1, A(0, 1, 8'h05), '0);
        chk("R4 cs slot1 on read", 32'(s_cs), 32'b001);
        chk("R5 no we on read", 32'(s_we), 32'b000);
        chk("R4 slot1 read", sys_rd_data, 32'h0100_0005);

        phase = "R6";
        acc(1, 0, A(0, 2, 8'h01), 32'h7777_7777);
        chk("R6 absent slot no cs", 32'(s_cs), 32'h0);
        chk("R6 absent slot no we", 32'(s_we), 32'h0);
        rd("R6 absent slot reads zero", A(0, 2, 8'h01), 32'h0);
        rd("R6 neighbour slot1 untouched", A(0, 1, 8'h00), 32'h0100_0000);

        phase = "R7";
        rd("R7 rng reg0 reset", A(1, 0, 0), RBASE);
        rd("R7 cipher reg1 reset", A(2, 0, 1), CBASE + 1);
        acc(1, 0, A(1, 0, 1), 32'h0000_00AB);
        acc(1, 0, A(2, 0, 0), 32'h0000_00CD);
        rd("R7 rng reg1 readback", A(1, 0, 1), 32'h0000_00AB);
        rd("R7 cipher reg0 readback", A(2, 0, 0), 32'h0000_00CD);
        rd("R7 rng reg0 unchanged", A(1, 0, 0), RBASE);

        phase = "R8";
        acc(1, 0, A(3, 0, 2), 32'hFFFF_FFFF);
        rd("R8 void segment", A(3, 0, 2), 32'h0);
        rd("R8 scratch not hit by void write", A(0, 0, 2), 32'h0BAD_F00D);
        rd("R8 hash slot above range", A(0, 5, 0), 32'h0);
        acc(1, 0, A(0, 0, 7), 32'h1234_5678);
        rd("R8 global reg7", A(0, 0, 7), 32'h0);
        acc(1, 0, A(1, 0, 2), 32'h1234_5678);
        rd("R8 rng reg2", A(1, 0, 2), 32'h0);
        acc(1, 0, A(2, 1, 0), 32'h1234_5678);
        rd("R8 cipher slot1", A(2, 1, 0), 32'h0);
        rd("R8 cipher reg0 kept", A(2, 0, 0), 32'h0000_00CD);

        phase = "R1";
        rd("R1 segment field picks rng", A(1, 0, 0), RBASE);
        rd("R1 core field picks slot1", A(0, 1, 8'hFF), 32'h0100_00FF);

        phase = "R9";
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        rd("R9 scratch cleared", A(0, 0, 2), 32'h0);
        rd("R9 rng reg1 restored", A(1, 0, 1), RBASE + 1);
        rd("R9 cipher reg0 restored", A(2, 0, 0), CBASE);

        repeat (2) @(posedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule